// File: doc/BRIEF.md
# Recursive Unsigned Multiplier

This block multiplies two unsigned operands of equal width and returns the full, untruncated product at twice that width. It is purely combinational: the product follows the operands with no clock and no state. Because the two operands cannot exceed 2^N−1 each, their product always stays below 2^(2N), so the output never loses a bit.

The structure is built by halving. An operand of width N is cut into an upper and a lower half. Four half-width multipliers produce the products high×high, high×low, low×high and low×low. The high×high and low×low results occupy disjoint bit ranges, so they are simply joined into one 2N-bit word. The two mixed products are summed first, then shifted up by N/2 bits and added to that joined word. Each level therefore needs exactly two adders instead of three. The same module instantiates itself at half width until the width reaches one. At that point a single AND gate forms the 1×1 product.

The operand width is a parameter and must be a power of two. Any other value stops elaboration. The design has no finite-state machine, so the block has no states and no transitions.

Top module: `rmul_top`

## Requirements
- R1: For any pair of operands, `prod` equals the exact unsigned product of `op_a` and `op_b` at full 2·OPW-bit width.
- R2: If either operand is zero, `prod` is zero.
- R3: If one operand equals 1, `prod` equals the other operand, zero-extended.
- R4: With both operands all ones, `prod` holds OPW−1 ones, then a single 0, then OPW−1 zeros, then a 1 at bit 0. This is read from the MSB down and is shown here for OPW > 1. The most significant product bit is set, so nothing is truncated.
- R5: If the upper halves (bits OPW−1 down to OPW/2) of both operands are zero, the upper OPW bits of `prod` are zero.
- R6: If `op_a` equals 2^k, `prod` equals `op_b` shifted left by k bits.
- R7: With OPW = 1 the block acts as one AND gate: `prod[0]` is `op_a & op_b` and `prod[1]` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | OPW | Multiplicand, unsigned |
| op_b | input | OPW | Multiplier, unsigned |
| prod | output | 2*OPW | Full unsigned product |

## Verification
Seeded random operand pairs exercise every quadrant of the split together with the carries between the two adders. A mismatch in any level of the recursion therefore shows up as a general error. Zero and unit operands expose a cross product that leaks into the result or a half that is dropped. Single-bit powers of two walk one partial product through every alignment offset, which catches a wrong shift amount. All-ones operands drive the longest carry chain into the top bit. Operand pairs that are small in both halves confirm that the high product region stays clear. An exhaustive run at width one checks the base cell on its own.

// File: rtl/rmul_pkg.sv
package rmul_pkg;

    // True when v is a positive power of two.
    function automatic bit is_pow2(input int v);
        return (v > 0) && ((v & (v - 1)) == 0);
    endfunction

endpackage

// File: rtl/rmul_and_cell.sv
// Base case of the recursion: a 1x1 product is a single AND gate.
module rmul_and_cell (
    input  logic       x,
    input  logic       y,
    output logic [1:0] p
);
    assign p = {1'b0, x & y};
endmodule

// File: rtl/rmul_adder.sv
// Unsigned adder; the inputs are zero-extended (or truncated) to the result width.
module rmul_adder #(
    parameter int IW = 4,
    parameter int OW = 5
) (
    input  logic [IW-1:0] a,
    input  logic [IW-1:0] b,
    output logic [OW-1:0] s
);
    assign s = OW'(a) + OW'(b);
endmodule

// File: rtl/rmul_node.sv
// One level of the halving recursion. Width N splits into two halves of H = N/2.
module rmul_node #(
    parameter int N = 2
) (
    input  logic [N-1:0]   x,
    input  logic [N-1:0]   y,
    output logic [2*N-1:0] p
);
    if (N == 1) begin : g_leaf
        rmul_and_cell u_cell (
            .x (x[0]),
            .y (y[0]),
            .p (p)
        );
    end else begin : g_split
        localparam int H = N / 2;

        logic [N-1:0]   p_ll;
        logic [N-1:0]   p_lh;
        logic [N-1:0]   p_hl;
        logic [N-1:0]   p_hh;
        logic [N:0]     cross_sum;
        logic [2*N-1:0] cross_w;
        logic [2*N-1:0] joined;

        rmul_node #(.N(H)) u_ll (.x(x[H-1:0]), .y(y[H-1:0]), .p(p_ll));
        rmul_node #(.N(H)) u_lh (.x(x[H-1:0]), .y(y[N-1:H]), .p(p_lh));
        rmul_node #(.N(H)) u_hl (.x(x[N-1:H]), .y(y[H-1:0]), .p(p_hl));
        rmul_node #(.N(H)) u_hh (.x(x[N-1:H]), .y(y[N-1:H]), .p(p_hh));

        // The high*high and low*low products occupy disjoint ranges.
        assign joined = {p_hh, p_ll};

        // Adder one: sum of the two mixed products, one carry bit kept.
        rmul_adder #(.IW(N), .OW(N + 1)) u_xsum (
            .a (p_lh),
            .b (p_hl),
            .s (cross_sum)
        );

        assign cross_w = {{(N - 1){1'b0}}, cross_sum} << H;

        // Adder two: align the mixed sum at weight 2^H and add it to the joined word.
        rmul_adder #(.IW(2 * N), .OW(2 * N)) u_fsum (
            .a (joined),
            .b (cross_w),
            .s (p)
        );
    end
endmodule

// File: rtl/rmul_top.sv
module rmul_top #(
    parameter int OPW = 16
) (
    input  logic [OPW-1:0]   op_a,
    input  logic [OPW-1:0]   op_b,
    output logic [2*OPW-1:0] prod
);
    if (!rmul_pkg::is_pow2(OPW)) begin : g_bad_width
        $error("rmul_top: OPW must be a power of two");
    end

    rmul_node #(.N(OPW)) u_root (
        .x (op_a),
        .y (op_b),
        .p (prod)
    );
endmodule

// File: rtl/rmul_checker.sv
module rmul_checker #(
    parameter int OPW = 16
) (
    input logic [OPW-1:0]   op_a,
    input logic [OPW-1:0]   op_b,
    input logic [2*OPW-1:0] prod
);
    // R2: a zero operand forces a zero product
    always_comb begin
        if (op_a == '0 || op_b == '0) begin
            a_r2_zero_in_zero_out: assert (prod == '0)
                else $error("R2 violated: prod=%0h", prod);
        end
    end

    // R3: a unit operand passes the other operand through
    always_comb begin
        if (op_a == OPW'(1)) begin
            a_r3_unit_a: assert (prod == {{OPW{1'b0}}, op_b})
                else $error("R3 violated: prod=%0h", prod);
        end
        if (op_b == OPW'(1)) begin
            a_r3_unit_b: assert (prod == {{OPW{1'b0}}, op_a})
                else $error("R3 violated: prod=%0h", prod);
        end
    end

    if (OPW > 1) begin : g_wide
        localparam int HALF = OPW / 2;

        // R4: the all-ones square reaches the top bit and ends in a one
        always_comb begin
            if (&op_a && &op_b) begin
                a_r4_no_truncation: assert (prod[2*OPW-1] && prod[0])
                    else $error("R4 violated: prod=%0h", prod);
            end
        end

        // R5: small operands keep the upper product half clear
        always_comb begin
            if (op_a[OPW-1:HALF] == '0 && op_b[OPW-1:HALF] == '0) begin
                a_r5_high_half_clear: assert (prod[2*OPW-1:OPW] == '0)
                    else $error("R5 violated: prod=%0h", prod);
            end
        end
    end else begin : g_unit
        // R7: the one-bit case never sets the upper bit
        always_comb begin
            a_r7_unit_top_clear: assert (prod[1] == 1'b0)
                else $error("R7 violated: prod=%0h", prod);
        end
    end
endmodule

bind rmul_top rmul_checker #(.OPW(OPW)) u_chk (
    .op_a (op_a),
    .op_b (op_b),
    .prod (prod)
);

// File: tb/sim_rmul_top.sv
module sim_rmul_top;
    localparam int N = 16;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic [N-1:0]   a;
    logic [N-1:0]   b;
    logic [2*N-1:0] p;
    logic           a1;
    logic           b1;
    logic [1:0]     p1;

    int n_cmp = 0;
    int n_bad = 0;

    rmul_top #(.OPW(N)) u0 (.op_a(a), .op_b(b), .prod(p));
    rmul_top #(.OPW(1)) u1 (.op_a(a1), .op_b(b1), .prod(p1));

    // Shift-and-add model at full width.
    function automatic logic [2*N-1:0] ref_mul(input logic [N-1:0] x, input logic [N-1:0] y);
        logic [2*N-1:0] acc = '0;
        for (int i = 0; i < N; i++) begin
            if (y[i]) acc = acc + ({{N{1'b0}}, x} << i);
        end
        return acc;
    endfunction

    task automatic check(input string req, input logic [2*N-1:0] got, input logic [2*N-1:0] exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: a=%0h b=%0h got=%0h exp=%0h", req, a, b, got, exp);
        end
    endtask

    task automatic apply(input logic [N-1:0] x, input logic [N-1:0] y);
        @(posedge clk);
        a = x;
        b = y;
        @(negedge clk);
    endtask

    initial begin
        #(200000 * 10);
        n_bad++;
        $display("FAIL watchdog: run did not complete, got=timeout exp=done");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic [N-1:0] rx;
        logic [N-1:0] ry;
        void'($urandom(32'd20240611));
        a  = '0;
        b  = '0;
        a1 = 1'b0;
        b1 = 1'b0;

        // Initial state: zero inputs give zero (R2)
        apply('0, '0);
        check("R2", p, '0);

        // R2: zero against varied operands
        apply('0, 16'hBEEF);
        check("R2", p, '0);
        apply(16'hFFFF, '0);
        check("R2", p, '0);

        // R3: unit operand
        apply(16'd1, 16'hA5C3);
        check("R3", p, 32'h0000A5C3);
        apply(16'hFFFF, 16'd1);
        check("R3", p, 32'h0000FFFF);

        // R4: all ones squared
        apply(16'hFFFF, 16'hFFFF);
        check("R4", p, {{(N-1){1'b1}}, 1'b0, {(N-1){1'b0}}, 1'b1});

        // R5: upper halves zero
        apply(16'h00FF, 16'h00FF);
        check("R5", p, 32'h0000FE01);
        for (int i = 0; i < 20; i++) begin
            rx = {8'h00, 8'($urandom)};
            ry = {8'h00, 8'($urandom)};
            apply(rx, ry);
            check("R5", {p[2*N-1:N], {N{1'b0}}}, '0);
        end

        // R6: powers of two on op_a, every shift offset
        for (int k = 0; k < N; k++) begin
            ry = 16'($urandom);
            apply(16'(1 << k), ry);
            check("R6", p, {{N{1'b0}}, ry} << k);
        end

        // R1: directed corners around half boundaries
        apply(16'h8000, 16'h8000);
        check("R1", p, 32'h40000000);
        apply(16'h0100, 16'h00FF);
        check("R1", p, ref_mul(16'h0100, 16'h00FF));
        apply(16'hFF00, 16'h00FF);
        check("R1", p, ref_mul(16'hFF00, 16'h00FF));

        // R1: seeded random pairs, with a commutation check
        for (int i = 0; i < 300; i++) begin
            rx = 16'($urandom);
            ry = 16'($urandom);
            apply(rx, ry);
            check("R1", p, ref_mul(rx, ry));
            apply(ry, rx);
            check("R1", p, ref_mul(rx, ry));
        end

        // R7: one-bit instance, exhaustive
        for (int i = 0; i < 4; i++) begin
            @(posedge clk);
            a1 = i[0];
            b1 = i[1];
            @(negedge clk);
            n_cmp++;
            if (p1 !== {1'b0, i[0] & i[1]}) begin
                n_bad++;
                $display("FAIL R7: a1=%0b b1=%0b got=%0b exp=%0b", a1, b1, p1, {1'b0, i[0] & i[1]});
            end
        end

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule